// File: doc/BRIEF.md
# Serial Identification Code Readout Sequencer

This block streams a fixed identification word out one bit at a time. The word is set when the design is built. It runs on the clock recovered from the reader field. While the field-present input is high, the block walks an address counter through the code store. The store is organised as rows by columns. The block holds each bit for a selectable number of field clock cycles, and it repeats the frame for as long as the field stays up.

The frame can be cut to a full, three-quarter, half or quarter length word. The bit period can be set to one of ten divider values, several of which are not powers of two. After the last bit of a frame, the next bit period carries the first bit again with no idle time.

When the field-present input drops, the counters clear. The next activation therefore always starts at the first bit. Three registered outputs go to the load modulator that follows:
- a data bit;
- a one-cycle strobe at the start of each bit;
- a one-cycle start-of-frame flag.

Top module: `idro_seq`

## Requirements
- R1: The bit at address a is CODE[a]. Addresses run upward from 0. The row index is a divided by COLS and the column index is a modulo COLS.
- R2: The length select picks the frame length: 0 gives 128 bits, 1 gives 96, 2 gives 64 and 3 gives 32. A frame carries addresses 0 up to length minus 1.
- R3: After the last bit of a frame, the very next bit period carries address 0. Frames repeat for as long as field_on stays high.
- R4: The rate select sets the bit period in rf_clk cycles. Codes 0 to 9 give 8, 16, 32, 40, 50, 64, 80, 100, 128 and 256. Codes 10 to 15 give 256.
- R5: bit_stb_o is high for exactly one rf_clk cycle at the start of each bit period. data_o changes only in that cycle.
- R6: sof_o is high for one cycle, together with the strobe of address 0, and at no other time.
- R7: While field_on is low, all three outputs read 0 one clock later. The first rf_clk edge with field_on high produces the strobe, the start-of-frame flag and bit 0.
- R8: A rate select change does not alter the bit period in progress. It takes effect from the next bit period.
- R9: A length select change does not alter the frame in progress. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_clk | input | 1 | Clock recovered from the reader field |
| field_on | input | 1 | Field present; low holds the block cleared (synchronous) |
| len_sel | input | 2 | Frame length select (R2) |
| rate_sel | input | 4 | Bit period select (R4) |
| data_o | output | 1 | Current code bit |
| bit_stb_o | output | 1 | One-cycle strobe at each bit start |
| sof_o | output | 1 | One-cycle flag at the first bit of each frame |

## Verification
The bench builds the block with its default 128-bit store of 8 rows by 16 columns and a 9-bit period counter. This makes the 256-cycle period and the full-length frame reachable. It overrides CODE with an irregular pattern, so a swapped row or column index, or a frame that is off by one, shows up as a wrong bit. Each frame length and each divider code is run for more than two whole frames, including a reserved rate code, so the wrap from the last bit back to bit 0 is checked at every length. Directed runs then check the following:
- the outputs while the field is down;
- a field drop in the middle of a frame;
- a rate change in the middle of a bit;
- a length change in the middle of a frame.

// File: rtl/idro_pkg.sv
package idro_pkg;

  typedef enum logic [1:0] {
    LEN_FULL    = 2'd0,
    LEN_3QUART  = 2'd1,
    LEN_HALF    = 2'd2,
    LEN_QUARTER = 2'd3
  } len_sel_e;

  localparam int RATE_SEL_W = 4;
  localparam int LEN_SEL_W  = 2;

endpackage

// File: rtl/idro_rate_div.sv
module idro_rate_div #(
  parameter int CNT_W = 9
) (
  input  logic                           clk,
  input  logic                           clr,
  input  logic [idro_pkg::RATE_SEL_W-1:0] rate_sel,
  output logic                           start_o,
  output logic                           end_o
);

  logic [CNT_W-1:0] div_d;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    case (rate_sel)
      4'd0:    div_d = CNT_W'(8);
      4'd1:    div_d = CNT_W'(16);
      4'd2:    div_d = CNT_W'(32);
      4'd3:    div_d = CNT_W'(40);
      4'd4:    div_d = CNT_W'(50);
      4'd5:    div_d = CNT_W'(64);
      4'd6:    div_d = CNT_W'(80);
      4'd7:    div_d = CNT_W'(100);
      4'd8:    div_d = CNT_W'(128);
      default: div_d = CNT_W'(256);
    endcase
  end

  assign start_o = (cnt_q == '0);
  assign end_o   = (cnt_q == div_q - 1'b1);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      div_q <= div_d;
    end else if (end_o) begin
      cnt_q <= '0;
      div_q <= div_d;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the period counter never passes the active divisor
  p_cnt_below_div_r4: assert property (@(posedge clk) disable iff (clr)
    cnt_q < div_q);

  // R8: the divisor is only reloaded at a bit boundary
  p_div_held_mid_bit_r8: assert property (@(posedge clk) disable iff (clr)
    !end_o |=> $stable(div_q));

endmodule

// File: rtl/idro_addr_ctr.sv
module idro_addr_ctr #(
  parameter int CODE_BITS = 128,
  parameter int ADDR_W    = $clog2(CODE_BITS)
) (
  input  logic                          clk,
  input  logic                          clr,
  input  logic [idro_pkg::LEN_SEL_W-1:0] len_sel,
  input  logic                          step,
  output logic [ADDR_W-1:0]             addr_o
);

  localparam int LEN_W = ADDR_W + 1;

  logic [LEN_W-1:0]  len_d;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last;

  always_comb begin
    case (idro_pkg::len_sel_e'(len_sel))
      idro_pkg::LEN_FULL:   len_d = LEN_W'(CODE_BITS);
      idro_pkg::LEN_3QUART: len_d = LEN_W'((CODE_BITS * 3) / 4);
      idro_pkg::LEN_HALF:   len_d = LEN_W'(CODE_BITS / 2);
      default:              len_d = LEN_W'(CODE_BITS / 4);
    endcase
  end

  assign last   = ({1'b0, addr_q} == len_q - 1'b1);
  assign addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      addr_q <= '0;
      len_q  <= len_d;
    end else if (step) begin
      if (last) begin
        addr_q <= '0;
        len_q  <= len_d;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  // R2: the address stays inside the active frame
  p_addr_in_frame_r2: assert property (@(posedge clk) disable iff (clr)
    {1'b0, addr_q} < len_q);

  // R3: stepping past the last bit returns to address 0
  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (clr)
    (step && last) |=> (addr_q == '0));

  // R9: the frame length only changes at a frame boundary
  p_len_held_mid_frame_r9: assert property (@(posedge clk) disable iff (clr)
    !(step && last) |=> $stable(len_q));

endmodule

// File: rtl/idro_code_rom.sv
module idro_code_rom #(
  parameter int                   ROWS      = 8,
  parameter int                   COLS      = 16,
  parameter int                   CODE_BITS = ROWS * COLS,
  parameter int                   ADDR_W    = $clog2(CODE_BITS),
  parameter logic [CODE_BITS-1:0] CODE      = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bit_o
);

  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = $clog2(COLS);

  logic [COLS-1:0]  row_word [ROWS];
  logic [ROW_W-1:0] row_idx;
  logic [COL_W-1:0] col_idx;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_word[r] = CODE[r*COLS +: COLS];
  end

  assign row_idx = ROW_W'(addr >> COL_W);
  assign col_idx = addr[COL_W-1:0];
  assign bit_o   = row_word[row_idx][col_idx];

endmodule

// File: rtl/idro_seq.sv
module idro_seq #(
  parameter int                   ROWS      = 8,
  parameter int                   COLS      = 16,
  parameter int                   CODE_BITS = ROWS * COLS,
  parameter int                   CNT_W     = 9,
  parameter logic [CODE_BITS-1:0] CODE      = {CODE_BITS{1'b0}}
) (
  input  logic       rf_clk,
  input  logic       field_on,
  input  logic [1:0] len_sel,
  input  logic [3:0] rate_sel,
  output logic       data_o,
  output logic       bit_stb_o,
  output logic       sof_o
);

  localparam int ADDR_W = $clog2(CODE_BITS);

  logic              clr;
  logic              bit_start;
  logic              bit_end;
  logic [ADDR_W-1:0] addr;
  logic              rom_bit;

  assign clr = ~field_on;

  idro_rate_div #(.CNT_W(CNT_W)) u_div (
    .clk      (rf_clk),
    .clr      (clr),
    .rate_sel (rate_sel),
    .start_o  (bit_start),
    .end_o    (bit_end)
  );

  idro_addr_ctr #(.CODE_BITS(CODE_BITS), .ADDR_W(ADDR_W)) u_addr (
    .clk     (rf_clk),
    .clr     (clr),
    .len_sel (len_sel),
    .step    (bit_end),
    .addr_o  (addr)
  );

  idro_code_rom #(
    .ROWS(ROWS), .COLS(COLS), .CODE_BITS(CODE_BITS),
    .ADDR_W(ADDR_W), .CODE(CODE)
  ) u_rom (
    .addr  (addr),
    .bit_o (rom_bit)
  );

  always_ff @(posedge rf_clk) begin
    if (clr) begin
      data_o    <= 1'b0;
      bit_stb_o <= 1'b0;
      sof_o     <= 1'b0;
    end else begin
      bit_stb_o <= bit_start;
      sof_o     <= bit_start && (addr == '0);
      if (bit_start) data_o <= rom_bit;
    end
  end

  // R6: a frame start is always a bit start
  p_sof_with_stb_r6: assert property (@(posedge rf_clk) disable iff (clr)
    sof_o |-> bit_stb_o);

  // R5: data only moves in a strobe cycle
  p_hold_between_stb_r5: assert property (@(posedge rf_clk) disable iff (clr)
    ($past(field_on) && !bit_stb_o) |-> $stable(data_o));

  // R7: field release starts a fresh frame on the first edge
  p_start_bit0_r7: assert property (@(posedge rf_clk) disable iff (clr)
    !$past(field_on) |=> (sof_o && bit_stb_o));

endmodule

// File: tb/idro_seq_bench.sv
module idro_seq_bench;

  localparam logic [127:0] TB_CODE = 128'hD3A5_0F96_71E2_C43B_5A69_E887_1CA5_B4C3;

  typedef struct packed {
    logic [1:0] len;
    logic [3:0] rate;
    int         len_n;
    int         div_n;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  128, 8},
    '{2'd1, 4'd3,  96,  40},
    '{2'd2, 4'd4,  64,  50},
    '{2'd3, 4'd9,  32,  256},
    '{2'd0, 4'd6,  128, 80},
    '{2'd3, 4'd7,  32,  100},
    '{2'd2, 4'd1,  64,  16},
    '{2'd1, 4'd2,  96,  32},
    '{2'd3, 4'd5,  32,  64},
    '{2'd2, 4'd8,  64,  128},
    '{2'd3, 4'd12, 32,  256}
  };

  logic       clk = 1'b0;
  logic       field_on = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic [3:0] rate_sel = 4'd0;
  logic       data_o, bit_stb_o, sof_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  idro_seq #(.CODE(TB_CODE)) u_idro_seq (
    .rf_clk    (clk),
    .field_on  (field_on),
    .len_sel   (len_sel),
    .rate_sel  (rate_sel),
    .data_o    (data_o),
    .bit_stb_o (bit_stb_o),
    .sof_o     (sof_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for the next strobe; per = cycles waited, moved = data changed while no strobe
  task automatic next_bit(output int per, output logic d, output logic s, output bit moved);
    logic d0;
    per = 0;
    moved = 1'b0;
    d0 = data_o;
    do begin
      @(negedge clk);
      per++;
      if (!bit_stb_o && data_o !== d0) moved = 1'b1;
    end while (!bit_stb_o);
    d = data_o;
    s = sof_o;
  endtask

  task automatic start_run(input logic [1:0] l, input logic [3:0] r);
    @(negedge clk);
    field_on = 1'b0;
    len_sel  = l;
    rate_sel = r;
    repeat (2) @(negedge clk);
    field_on = 1'b1;
  endtask

  initial begin
    int per;
    logic d, s;
    bit mv;
    int idx;

    // reset state with field down (R7)
    repeat (5) @(negedge clk);
    chk(bit_stb_o == 1'b0 && sof_o == 1'b0 && data_o == 1'b0, "R7 idle outputs",
        {29'd0, bit_stb_o, sof_o, data_o}, 0);

    // table walk: every length and divider, over two frames and a bit
    for (int v = 0; v < NV; v++) begin
      start_run(VECS[v].len, VECS[v].rate);
      for (int i = 0; i < 2 * VECS[v].len_n + 2; i++) begin
        next_bit(per, d, s, mv);
        idx = i % VECS[v].len_n;
        chk(per == ((i == 0) ? 1 : VECS[v].div_n), "R4 bit period", per,
            (i == 0) ? 1 : VECS[v].div_n);
        chk(d == TB_CODE[idx], "R1 data bit", int'(d), int'(TB_CODE[idx]));
        chk(s == (idx == 0), "R3/R6 frame start", int'(s), int'(idx == 0));
        chk(!mv, "R5 data held", int'(mv), 0);
      end
    end

    // field drop mid-frame clears, restart at bit 0 (R7)
    start_run(2'd3, 4'd0);
    for (int i = 0; i < 10; i++) next_bit(per, d, s, mv);
    @(negedge clk);
    field_on = 1'b0;
    @(negedge clk);
    chk(bit_stb_o == 1'b0 && sof_o == 1'b0 && data_o == 1'b0, "R7 cleared on drop",
        {29'd0, bit_stb_o, sof_o, data_o}, 0);
    field_on = 1'b1;
    next_bit(per, d, s, mv);
    chk(per == 1, "R7 first edge strobe", per, 1);
    chk(d == TB_CODE[0] && s == 1'b1, "R7 restart bit 0", {30'd0, d, s},
        {30'd0, TB_CODE[0], 1'b1});

    // rate change mid-bit applies from the next bit (R8)
    start_run(2'd0, 4'd0);
    next_bit(per, d, s, mv);
    next_bit(per, d, s, mv);
    rate_sel = 4'd3;
    next_bit(per, d, s, mv);
    chk(per == 8, "R8 current period kept", per, 8);
    next_bit(per, d, s, mv);
    chk(per == 40, "R8 new period", per, 40);
    chk(d == TB_CODE[3], "R8 data continues", int'(d), int'(TB_CODE[3]));

    // length change mid-frame applies from the next frame (R9)
    start_run(2'd3, 4'd0);
    for (int k = 0; k < 5; k++) next_bit(per, d, s, mv);
    len_sel = 2'd2;
    for (int k = 5; k < 98; k++) begin
      next_bit(per, d, s, mv);
      idx = (k < 32) ? k : (k - 32) % 64;
      chk(s == (k == 32 || k == 96), "R9 frame boundary", int'(s), int'(k == 32 || k == 96));
      chk(d == TB_CODE[idx], "R9 data after change", int'(d), int'(TB_CODE[idx]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule